// File: doc/BRIEF.md
# Privileged System Word Decoder

This block sits beside the main instruction decoder and classifies 32-bit words that carry the system opcode or the memory-ordering opcode but no CSR operand. Each word comes with a valid strobe. In the same cycle, the block returns one request pulse and the value that goes with it. The pulse types are a trap request with its cause number, a return-from-trap request with the privilege level to return to, a wait-for-interrupt request, an address-translation fence with its two register indices, a data-ordering fence with its predecessor and successor sets, and an instruction-stream fence with its 12-bit immediate. System-opcode words that encode CSR accesses are not decoded here. They raise a single detection flag, and a separate CSR unit handles them.

Matching uses exact whole-word patterns, not the opcode alone. A system-opcode word with a zero minor-function field that matches none of the known patterns is reported as an illegal instruction. Examples are a word with a stray register index, or a word with an unknown function code. All outputs are combinational. They are qualified by the strobe and by reset, so the surrounding pipeline stage decides when they take effect. Acting on the trap, changing privilege state and flushing memory are left to the consumer.

Top module: `sysins_decoder`

## Requirements
- R1: While `rst_n` is low, every request, flag and value output is zero, whatever is on `in_valid` and `in_word`.
- R2: When `in_valid` is low, every request, flag and value output is zero in that cycle.
- R3: Word 0x00000073 raises `trap_req` with `trap_cause` = 11.
- R4: Word 0x00100073 raises `trap_req` with `trap_cause` = 3.
- R5: Words 0x00200073, 0x10200073 and 0x30200073 raise `ret_req` with `ret_level` 0, 1 and 3 respectively. Bits [31:25] are {2'b00, level, 3'b000}, bits [24:20] are 00010, and bits [19:7] are zero.
- R6: Word 0x10500073 raises `wait_req`.
- R7: A word with bits [31:25] = 0001001, bits [14:12] = 000, bits [11:7] = 0 and opcode 1110011 raises `xlat_fence_req`. It drives `xlat_rs1` from bits [19:15] and `xlat_rs2` from bits [24:20].
- R8: Opcode 0001111 with bits [14:12] = 000 raises `order_fence_req`. `order_sets` is predecessor (bits [27:24]) shifted left by 4, ORed with successor (bits [23:20]).
- R9: Opcode 0001111 with bits [14:12] = 001 raises `ifetch_fence_req`, and `ifetch_imm` takes bits [31:20].
- R10: Any other opcode-1110011 word with bits [14:12] = 000 raises `trap_req` with `trap_cause` = 2.
- R11: An opcode-1110011 word with bits [14:12] nonzero raises only `csr_seen`.
- R12: `flow_break` is high exactly when `trap_req` or `ret_req` is high. WFI and all fences leave it low.
- R13: At most one request or flag is high at a time. Other opcodes, and opcode 0001111 with other minor codes, raise nothing. A value output is zero when its request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset; forces all outputs to zero |
| in_valid | input | 1 | Strobe qualifying `in_word` |
| in_word | input | 32 | Instruction word to classify |
| trap_req | output | 1 | Trap request pulse |
| trap_cause | output | 4 | Cause number accompanying `trap_req` |
| ret_req | output | 1 | Return-from-trap request pulse |
| ret_level | output | 2 | Privilege level to return to |
| wait_req | output | 1 | Wait-for-interrupt request pulse |
| xlat_fence_req | output | 1 | Address-translation fence pulse |
| xlat_rs1 | output | 5 | First register index of that fence |
| xlat_rs2 | output | 5 | Second register index of that fence |
| order_fence_req | output | 1 | Data-ordering fence pulse |
| order_sets | output | 8 | Predecessor and successor sets, packed |
| ifetch_fence_req | output | 1 | Instruction-stream fence pulse |
| ifetch_imm | output | 12 | Immediate of the instruction-stream fence |
| csr_seen | output | 1 | Word is a CSR-access system instruction |
| flow_break | output | 1 | Sequential flow does not continue after this word |

## Verification
The embedded checks assume that `in_valid` and `in_word` are stable from just after one rising edge until the next. They also assume `rst_n` is held low for at least one edge before use. Under those assumptions, they may claim mutual exclusion of the requests and a cause set limited to 2, 3 and 11. The bench changes inputs only on the falling clock edge and samples outputs before the following rising edge, so every rising edge sees a settled word. Its stimulus covers each exact pattern, near-miss words that differ in a single register field, CSR words, unrelated opcodes and cycles with the strobe low.

// File: rtl/sysdec_pkg.sv
// Package: shared field layout and opcode constants for the system word decoder.
// Assumes a 32-bit base instruction format with the opcode in bits [6:0].
package sysdec_pkg;

    localparam int WORD_W = 32;
    localparam int REG_W  = 5;
    localparam int F3_W   = 3;
    localparam int F7_W   = 7;
    localparam int OPC_W  = 7;
    localparam int IMM_W  = 12;

    localparam logic [OPC_W-1:0] OPC_SYSTEM  = 7'b1110011;
    localparam logic [OPC_W-1:0] OPC_MEMORD  = 7'b0001111;

    localparam logic [REG_W-1:0] RS2_XRET    = 5'b00010;
    localparam logic [REG_W-1:0] RS2_WFI     = 5'b00101;
    localparam logic [F7_W-1:0]  F7_WFI      = 7'b0001000;
    localparam logic [F7_W-1:0]  F7_XLATFENCE = 7'b0001001;

    // Split view of a base-format word.
    typedef struct packed {
        logic [F7_W-1:0]  funct7;
        logic [REG_W-1:0] rs2;
        logic [REG_W-1:0] rs1;
        logic [F3_W-1:0]  funct3;
        logic [REG_W-1:0] rd;
        logic [OPC_W-1:0] opcode;
    } word_fields_t;

endpackage

// File: rtl/sysdec_fields.sv
// Module: sysdec_fields
// Splits a raw instruction word into named fields. Pure wiring; assumes the
// package layout matches the word width.
module sysdec_fields
    import sysdec_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output word_fields_t      fields_o
);

    // Reinterpret the word as the field struct.
    always_comb begin
        fields_o = word_fields_t'(word_i);
    end

endmodule

// File: rtl/sysdec_sys_match.sv
// Module: sysdec_sys_match
// Classifies system-opcode words: environment call, breakpoint, the trap
// returns (one matcher per level, generated), wait, address-translation
// fence, illegal leftovers and CSR forms. Assumes qual_i already folds in
// the strobe and reset; all outputs are zero when qual_i is low.
module sysdec_sys_match
    import sysdec_pkg::*;
#(
    parameter int                 CAUSE_W       = 4,
    parameter int                 LEVEL_W       = 2,
    parameter int                 NUM_RET       = 3,
    parameter logic [CAUSE_W-1:0] CAUSE_ENVCALL = 4'd11,
    parameter logic [CAUSE_W-1:0] CAUSE_BREAK   = 4'd3,
    parameter logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               qual_i,
    input  word_fields_t       f_i,
    output logic               trap_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               ret_o,
    output logic [LEVEL_W-1:0] level_o,
    output logic               wait_o,
    output logic               xlat_o,
    output logic [REG_W-1:0]   xlat_rs1_o,
    output logic [REG_W-1:0]   xlat_rs2_o,
    output logic               csr_o
);

    // Return level served by matcher i: 0, 1, then 3 (level 2 is skipped).
    function automatic logic [LEVEL_W-1:0] level_of(input int idx);
        return (idx >= 2) ? LEVEL_W'(idx + 1) : LEVEL_W'(idx);
    endfunction

    logic                 is_sys;
    logic                 minor_zero;
    logic                 regs_zero;
    logic                 hit_envcall;
    logic                 hit_break;
    logic                 hit_wait;
    logic                 hit_xlat;
    logic                 hit_illegal;
    logic [NUM_RET-1:0]   hit_ret;
    logic [LEVEL_W-1:0]   lvl_terms [NUM_RET];

    // Opcode and common zero-field qualifiers.
    always_comb begin
        is_sys     = qual_i && (f_i.opcode == OPC_SYSTEM);
        minor_zero = (f_i.funct3 == '0);
        regs_zero  = (f_i.rs1 == '0) && (f_i.rd == '0);
    end

    // Exact patterns for call, breakpoint, wait and translation fence.
    always_comb begin
        hit_envcall = is_sys && minor_zero && regs_zero &&
                      (f_i.funct7 == '0) && (f_i.rs2 == 5'd0);
        hit_break   = is_sys && minor_zero && regs_zero &&
                      (f_i.funct7 == '0) && (f_i.rs2 == 5'd1);
        hit_wait    = is_sys && minor_zero && regs_zero &&
                      (f_i.funct7 == F7_WFI) && (f_i.rs2 == RS2_WFI);
        hit_xlat    = is_sys && minor_zero && (f_i.rd == '0) &&
                      (f_i.funct7 == F7_XLATFENCE);
    end

    // One matcher per return level; its level is ORed into the output term.
    for (genvar gi = 0; gi < NUM_RET; gi++) begin : g_ret
        localparam logic [LEVEL_W-1:0] LVL = level_of(gi);
        localparam logic [F7_W-1:0]    F7  = F7_W'({LVL, 3'b000});
        // Match the return word for this level.
        always_comb begin
            hit_ret[gi]   = is_sys && minor_zero && regs_zero &&
                            (f_i.funct7 == F7) && (f_i.rs2 == RS2_XRET);
            lvl_terms[gi] = hit_ret[gi] ? LVL : '0;
        end
    end

    // Leftover zero-minor system words are illegal.
    always_comb begin
        hit_illegal = is_sys && minor_zero && !hit_envcall && !hit_break &&
                      !hit_wait && !hit_xlat && (hit_ret == '0);
    end

    // Drive request pulses and their values.
    always_comb begin
        trap_o  = hit_envcall || hit_break || hit_illegal;
        cause_o = '0;
        if (hit_envcall)      cause_o = CAUSE_ENVCALL;
        else if (hit_break)   cause_o = CAUSE_BREAK;
        else if (hit_illegal) cause_o = CAUSE_ILLEGAL;
        ret_o   = (hit_ret != '0);
        level_o = '0;
        for (int i = 0; i < NUM_RET; i++) level_o = level_o | lvl_terms[i];
        wait_o      = hit_wait;
        xlat_o      = hit_xlat;
        xlat_rs1_o  = hit_xlat ? f_i.rs1 : '0;
        xlat_rs2_o  = hit_xlat ? f_i.rs2 : '0;
        csr_o       = is_sys && !minor_zero;
    end

    // R13: the system-opcode classes never overlap.
    assert_sys_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_o, ret_o, wait_o, xlat_o, csr_o}));

    // R10: a trap only ever carries one of the three known causes.
    assert_cause_known_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (cause_o == CAUSE_ENVCALL || cause_o == CAUSE_BREAK ||
                    cause_o == CAUSE_ILLEGAL));

    // R5: a return never targets the reserved level 2.
    assert_ret_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_o |-> (level_o != LEVEL_W'(2)));

    // R11: a CSR form never reports a trap.
    assert_csr_no_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        csr_o |-> !trap_o);

endmodule

// File: rtl/sysdec_mem_match.sv
// Module: sysdec_mem_match
// Classifies memory-ordering opcode words into the data fence and the
// instruction-stream fence. Assumes qual_i folds in strobe and reset.
module sysdec_mem_match
    import sysdec_pkg::*;
#(
    parameter int SET_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 qual_i,
    input  logic [OPC_W-1:0]     opcode_i,
    input  logic [F3_W-1:0]      minor_i,
    input  logic [IMM_W-1:0]     imm_i,
    output logic                 order_o,
    output logic [2*SET_W-1:0]   sets_o,
    output logic                 ifetch_o,
    output logic [IMM_W-1:0]     ifetch_imm_o
);

    logic is_mem;

    // Select the fence flavour from the minor code.
    always_comb begin
        is_mem       = qual_i && (opcode_i == OPC_MEMORD);
        order_o      = is_mem && (minor_i == 3'b000);
        ifetch_o     = is_mem && (minor_i == 3'b001);
        sets_o       = order_o ? {imm_i[2*SET_W-1:SET_W], imm_i[SET_W-1:0]} : '0;
        ifetch_imm_o = ifetch_o ? imm_i : '0;
    end

    // R13: the two fence flavours are exclusive.
    assert_fence_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(order_o && ifetch_o));

    // R2: no fence without the qualifier.
    assert_fence_needs_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_i |-> (!order_o && !ifetch_o && sets_o == '0));

endmodule

// File: rtl/sysins_decoder.sv
// Module: sysins_decoder (top)
// Combinational classifier for system and memory-ordering words without a
// CSR operand. Outputs are pulses qualified by in_valid and held at zero
// while the synchronous active-low reset is asserted. Assumes the word is
// stable across the cycle in which in_valid is high.
module sysins_decoder
    import sysdec_pkg::*;
#(
    parameter int CAUSE_W = 4,
    parameter int LEVEL_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        in_word,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic               ret_req,
    output logic [LEVEL_W-1:0] ret_level,
    output logic               wait_req,
    output logic               xlat_fence_req,
    output logic [4:0]         xlat_rs1,
    output logic [4:0]         xlat_rs2,
    output logic               order_fence_req,
    output logic [7:0]         order_sets,
    output logic               ifetch_fence_req,
    output logic [11:0]        ifetch_imm,
    output logic               csr_seen,
    output logic               flow_break
);

    localparam int SET_W = 4;

    logic         qual;
    word_fields_t fields;

    // Strobe qualified by reset.
    always_comb begin
        qual = in_valid && rst_n;
    end

    sysdec_fields u_fields (
        .word_i   (in_word),
        .fields_o (fields)
    );

    sysdec_sys_match #(
        .CAUSE_W (CAUSE_W),
        .LEVEL_W (LEVEL_W)
    ) u_sys (
        .clk        (clk),
        .rst_n      (rst_n),
        .qual_i     (qual),
        .f_i        (fields),
        .trap_o     (trap_req),
        .cause_o    (trap_cause),
        .ret_o      (ret_req),
        .level_o    (ret_level),
        .wait_o     (wait_req),
        .xlat_o     (xlat_fence_req),
        .xlat_rs1_o (xlat_rs1),
        .xlat_rs2_o (xlat_rs2),
        .csr_o      (csr_seen)
    );

    sysdec_mem_match #(
        .SET_W (SET_W)
    ) u_mem (
        .clk          (clk),
        .rst_n        (rst_n),
        .qual_i       (qual),
        .opcode_i     (fields.opcode),
        .minor_i      (fields.funct3),
        .imm_i        ({fields.funct7, fields.rs2}),
        .order_o      (order_fence_req),
        .sets_o       (order_sets),
        .ifetch_o     (ifetch_fence_req),
        .ifetch_imm_o (ifetch_imm)
    );

    // Sequential flow stops after any trap or return.
    always_comb begin
        flow_break = trap_req || ret_req;
    end

    // R13: across both matchers at most one request or flag is active.
    assert_req_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_req, ret_req, wait_req, xlat_fence_req,
                  order_fence_req, ifetch_fence_req, csr_seen}));

    // R2: an idle strobe leaves every request and the flow flag low.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !(flow_break || wait_req || xlat_fence_req ||
                        order_fence_req || ifetch_fence_req || csr_seen));

    // R12: wait and fence requests keep sequential flow.
    assert_wait_continues_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req || order_fence_req || ifetch_fence_req || xlat_fence_req) |-> !flow_break);

endmodule

// File: tb/sysins_decoder_tb.sv
// Bench for sysins_decoder: a vector table walked by one loop, then
// directed reset and strobe checks. Inputs change on the falling edge,
// outputs are sampled 1 ns later, before the next rising edge.
module sysins_decoder_tb;

    // Vector: {req tag, valid, word, flags, payload}
    // flags   = {trap, ret, wait, order, ifetch, xlat, csr, flow}
    // payload = {cause4, level2, sets8, imm12, rs1_5, rs2_5}
    localparam int VEC_W = 4 + 1 + 32 + 8 + 36;
    localparam int NVEC  = 19;

    localparam logic [VEC_W-1:0] VECS [NVEC] = '{
        {4'd3,  1'b1, 32'h00000073, 8'h81, 4'd11, 2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R3 call
        {4'd4,  1'b1, 32'h00100073, 8'h81, 4'd3,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R4 breakpoint
        {4'd5,  1'b1, 32'h00200073, 8'h41, 4'd0,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R5 level 0
        {4'd5,  1'b1, 32'h10200073, 8'h41, 4'd0,  2'd1, 8'h00, 12'h000, 5'd0, 5'd0}, // R5 level 1
        {4'd5,  1'b1, 32'h30200073, 8'h41, 4'd0,  2'd3, 8'h00, 12'h000, 5'd0, 5'd0}, // R5 level 3
        {4'd6,  1'b1, 32'h10500073, 8'h20, 4'd0,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R6 wait, R12
        {4'd7,  1'b1, 32'h12928073, 8'h04, 4'd0,  2'd0, 8'h00, 12'h000, 5'd5, 5'd9}, // R7 xlat fence
        {4'd8,  1'b1, 32'h0A50000F, 8'h10, 4'd0,  2'd0, 8'hA5, 12'h000, 5'd0, 5'd0}, // R8 order fence
        {4'd9,  1'b1, 32'h1230100F, 8'h08, 4'd0,  2'd0, 8'h00, 12'h123, 5'd0, 5'd0}, // R9 ifetch fence
        {4'd10, 1'b1, 32'h000000F3, 8'h81, 4'd2,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R10 call with rd
        {4'd10, 1'b1, 32'h00300073, 8'h81, 4'd2,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R10 unknown code
        {4'd10, 1'b1, 32'h129280F3, 8'h81, 4'd2,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R10 xlat with rd
        {4'd10, 1'b1, 32'h30208073, 8'h81, 4'd2,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R10 return with rs1
        {4'd10, 1'b1, 32'h10508073, 8'h81, 4'd2,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R10 wait with rs1
        {4'd11, 1'b1, 32'h34011073, 8'h02, 4'd0,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R11 csr write
        {4'd11, 1'b1, 32'h00004073, 8'h02, 4'd0,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R11 minor 100
        {4'd13, 1'b1, 32'h00000033, 8'h00, 4'd0,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R13 other opcode
        {4'd13, 1'b1, 32'h0000200F, 8'h00, 4'd0,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}, // R13 other fence code
        {4'd2,  1'b0, 32'h00000073, 8'h00, 4'd0,  2'd0, 8'h00, 12'h000, 5'd0, 5'd0}  // R2 strobe low
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_word;
    logic        trap_req, ret_req, wait_req, xlat_fence_req;
    logic        order_fence_req, ifetch_fence_req, csr_seen, flow_break;
    logic [3:0]  trap_cause;
    logic [1:0]  ret_level;
    logic [4:0]  xlat_rs1, xlat_rs2;
    logic [7:0]  order_sets;
    logic [11:0] ifetch_imm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sysins_decoder u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .in_valid         (in_valid),
        .in_word          (in_word),
        .trap_req         (trap_req),
        .trap_cause       (trap_cause),
        .ret_req          (ret_req),
        .ret_level        (ret_level),
        .wait_req         (wait_req),
        .xlat_fence_req   (xlat_fence_req),
        .xlat_rs1         (xlat_rs1),
        .xlat_rs2         (xlat_rs2),
        .order_fence_req  (order_fence_req),
        .order_sets       (order_sets),
        .ifetch_fence_req (ifetch_fence_req),
        .ifetch_imm       (ifetch_imm),
        .csr_seen         (csr_seen),
        .flow_break       (flow_break)
    );

    function automatic logic [43:0] observed();
        return {trap_req, ret_req, wait_req, order_fence_req, ifetch_fence_req,
                xlat_fence_req, csr_seen, flow_break,
                trap_cause, ret_level, order_sets, ifetch_imm, xlat_rs1, xlat_rs2};
    endfunction

    task automatic apply_and_check(input int tag, input logic v, input logic [31:0] w,
                                   input logic [43:0] exp);
        @(negedge clk);
        in_valid = v;
        in_word  = w;
        #1;
        n_checks++;
        if (observed() !== exp) begin
            n_fail++;
            $display("FAIL R%0d word=%h actual=%h expected=%h", tag, w, observed(), exp);
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_word  = '0;
        // R1: reset forces everything low even with a valid call word.
        apply_and_check(1, 1'b1, 32'h00000073, 44'h0);
        apply_and_check(1, 1'b1, 32'h0A50000F, 44'h0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            apply_and_check(int'(VECS[i][VEC_W-1 -: 4]), VECS[i][VEC_W-5],
                            VECS[i][75:44], VECS[i][43:0]);
        end
        // R2: valid call, then the strobe drops with the word held.
        apply_and_check(3, 1'b1, 32'h00000073, {8'h81, 4'd11, 32'h0});
        apply_and_check(2, 1'b0, 32'h00000073, 44'h0);
        // R12: return breaks flow; a fence right after does not.
        apply_and_check(12, 1'b1, 32'h30200073, {8'h41, 4'd0, 2'd3, 30'h0});
        apply_and_check(12, 1'b1, 32'h0FF0000F, {8'h10, 4'd0, 2'd0, 8'hFF, 22'h0});
        // R1: reset asserted again mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        apply_and_check(1, 1'b1, 32'h00100073, 44'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule